// File: doc/BRIEF.md
# Isochronous IN DMA Request Generator

This block produces the DMA request line for a single isochronous IN endpoint channel of a USB device controller. Software binds the channel to an endpoint by writing a non-zero endpoint number into a configuration field. It then loads a per-frame byte count and sets a start bit. From that point the block asks the system DMA controller for data. The first request goes out once the endpoint buffer is empty. Each later request goes out on a start-of-frame pulse, nominally every millisecond.

While a request is up, every DMA write strobe counts one byte into the endpoint buffer. The request is withdrawn in the same cycle that the count reaches the programmed size. The request repeats every frame for as long as the channel stays enabled. There is no end-of-transfer control and no interrupt. A programmed size larger than the endpoint buffer is flagged on an error output, and no request is issued while it stands.

Top module: `iso_in_dma_req`

## Requirements
- R1: After reset, with the start bit low, `dma_req` and `size_err` are both low.
- R2: The channel is enabled only when `ctl_start` is 1 and `cfg_ep` is non-zero (zero means no endpoint). When the channel is enabled with `buf_empty` high, `dma_req` is high after the first rising clock edge.
- R3: When the channel is enabled while `buf_empty` is low, `dma_req` stays low until `buf_empty` goes high or an `sof` pulse is seen. In either case it rises after the next clock edge.
- R4: Each clock edge with both `dma_req` and `dma_wr` high counts one byte. `dma_req` falls in the cycle the count equals `ctl_size`, which is after exactly `ctl_size` strobes. Strobes while `dma_req` is low are not counted.
- R5: An `sof` pulse while the channel is enabled clears the count and re-arms the request, so `dma_req` is high after that edge. This repeats for every frame without limit.
- R6: An `sof` pulse while a request is still pending restarts the count, so a further full `ctl_size` strobes are needed before `dma_req` falls.
- R7: Clearing `ctl_start`, or writing 0 to `cfg_ep`, drops `dma_req` in the same cycle and clears the count. On re-enable, the channel again waits for an empty buffer or an `sof` pulse.
- R8: While the channel is enabled, `size_err` is high exactly when `ctl_size > buf_size`, and `dma_req` stays low for as long as it is high. A size equal to `buf_size` is legal.
- R9: A `ctl_size` of zero never raises `dma_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ep | input | EP_W | Endpoint number bound to this channel, 0 = unassigned |
| ctl_start | input | 1 | Start bit, holds the channel active while 1 |
| ctl_size | input | CNT_W | Bytes to move per frame |
| buf_size | input | CNT_W | Capacity of the endpoint buffer in bytes |
| buf_empty | input | 1 | Endpoint buffer is empty |
| sof | input | 1 | One-cycle start-of-frame pulse |
| dma_wr | input | 1 | DMA write strobe, one byte into the buffer |
| dma_req | output | 1 | Request to the system DMA controller |
| size_err | output | 1 | Programmed size exceeds the buffer size |

## Verification
The bench sweeps every size from 0 to 7 against a buffer of 4 over several frames. A counter that is off by one would drop the request one strobe early or late. A size of zero or an oversized request that leaked through would show a request where none is allowed. A full grid of size against buffer capacity catches a comparison that treats the equal case as an error. Separate cases check the following:
- An `sof` arriving mid-transfer: a design that kept the old count ends the frame early.
- A transfer started with a full buffer: a design that armed at once requests too soon.
- Disabling and re-enabling the channel mid-frame: a design that kept its count or its armed state would resume the old frame instead of waiting for the next one.

// File: rtl/iso_dma_pkg.sv
// Shared types for the isochronous IN DMA request generator.
package iso_dma_pkg;
    // Arming state of one channel within the current frame.
    typedef enum logic [1:0] {
        ARM_OFF   = 2'd0,   // channel disabled
        ARM_WAIT  = 2'd1,   // enabled, waiting for empty buffer or SOF
        ARM_FRAME = 2'd2    // request window open for this frame
    } arm_state_e;
endpackage

// File: rtl/iso_size_guard.sv
// Compares the programmed per-frame size against the buffer capacity.
// Assumes both values are unsigned byte counts of the same width.
module iso_size_guard #(
    parameter int CNT_W = 11
) (
    input  logic [CNT_W-1:0] size,
    input  logic [CNT_W-1:0] limit,
    output logic             too_big
);
    // Flag a size that would overrun the endpoint buffer.
    always_comb begin
        too_big = (size > limit);
    end
endmodule

// File: rtl/iso_arm_fsm.sv
// Tracks whether the channel's request window is open for this frame.
// The window opens on the first empty buffer after enable, or on any SOF.
// Assumes sof is a single-cycle pulse in the clk domain.
module iso_arm_fsm
    import iso_dma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic buf_empty,
    input  logic sof,
    output logic frame_start,
    output logic frame_active
);
    arm_state_e state_q, state_d;

    // Open a new frame window on SOF, or on the first empty buffer before one is open.
    always_comb begin
        frame_start = enable & (sof | ((state_q != ARM_FRAME) & buf_empty));
    end

    // Next-state selection.
    always_comb begin
        if (!enable)                    state_d = ARM_OFF;
        else if (frame_start)           state_d = ARM_FRAME;
        else if (state_q == ARM_FRAME)  state_d = ARM_FRAME;
        else                            state_d = ARM_WAIT;
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ARM_OFF;
        else        state_q <= state_d;
    end

    // Window output for the request logic.
    always_comb begin
        frame_active = (state_q == ARM_FRAME);
    end

    // R7
    disabled_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state_q == ARM_OFF));

    // R5
    sof_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && sof) |=> (state_q == ARM_FRAME));

    // R3
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && (state_q != ARM_FRAME) && !buf_empty && !sof) |=> (state_q != ARM_FRAME));
endmodule

// File: rtl/iso_byte_counter.sv
// Per-frame byte counter. A clear wins over an increment in the same cycle.
// Assumes the caller never increments past the programmed size.
module iso_byte_counter #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_q;

    // Count accepted DMA writes, restarting on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clear) cnt_q <= '0;
        else if (inc)   cnt_q <= cnt_q + 1'b1;
    end

    assign cnt = cnt_q;

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clear) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R6
    count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));
endmodule

// File: rtl/iso_in_dma_req.sv
// Isochronous IN DMA request generator for one device-controller channel.
// Raises dma_req once per frame until ctl_size bytes have been written.
// Assumes ctl_size and buf_size are held steady while the channel is enabled.
module iso_in_dma_req #(
    parameter int CNT_W = 11,
    parameter int EP_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EP_W-1:0]  cfg_ep,
    input  logic             ctl_start,
    input  logic [CNT_W-1:0] ctl_size,
    input  logic [CNT_W-1:0] buf_size,
    input  logic             buf_empty,
    input  logic             sof,
    input  logic             dma_wr,
    output logic             dma_req,
    output logic             size_err
);
    logic             enable;
    logic             too_big;
    logic             frame_start;
    logic             frame_active;
    logic             cnt_clear;
    logic             cnt_inc;
    logic [CNT_W-1:0] byte_cnt;

    // Channel runs only when started and bound to a real endpoint.
    always_comb begin
        enable = ctl_start & (cfg_ep != '0);
    end

    iso_size_guard #(.CNT_W(CNT_W)) u_guard (
        .size    (ctl_size),
        .limit   (buf_size),
        .too_big (too_big)
    );

    iso_arm_fsm u_arm (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .buf_empty    (buf_empty),
        .sof          (sof),
        .frame_start  (frame_start),
        .frame_active (frame_active)
    );

    // Restart the count on disable or a new frame; count accepted strobes.
    always_comb begin
        cnt_clear = ~enable | frame_start;
        cnt_inc   = dma_req & dma_wr;
    end

    iso_byte_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clear),
        .inc   (cnt_inc),
        .cnt   (byte_cnt)
    );

    // Request while the frame window is open and bytes remain.
    always_comb begin
        size_err = enable & too_big;
        dma_req  = frame_active & enable & ~too_big & (byte_cnt != ctl_size);
    end

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !size_err) |-> (byte_cnt <= ctl_size));

    // R8
    err_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (size_err && !frame_start) |=> $stable(byte_cnt));
endmodule

// File: tb/iso_in_dma_req_tb.sv
module iso_in_dma_req_tb;
    localparam int CNT_W = 11;
    localparam int EP_W  = 4;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [EP_W-1:0]  cfg_ep;
    logic             ctl_start;
    logic [CNT_W-1:0] ctl_size;
    logic [CNT_W-1:0] buf_size;
    logic             buf_empty;
    logic             sof;
    logic             dma_wr;
    logic             dma_req;
    logic             size_err;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;   // 250 MHz

    iso_in_dma_req #(.CNT_W(CNT_W), .EP_W(EP_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_ep(cfg_ep), .ctl_start(ctl_start),
        .ctl_size(ctl_size), .buf_size(buf_size), .buf_empty(buf_empty),
        .sof(sof), .dma_wr(dma_wr), .dma_req(dma_req), .size_err(size_err)
    );

    task automatic chk(input string rq, input string what, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    // Advance past the next rising edge; inputs change just after it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cfg_ep = '0; ctl_start = 1'b0; ctl_size = '0;
        buf_size = 11'd4; buf_empty = 1'b0; sof = 1'b0; dma_wr = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
    endtask

    // One write strobe held across one rising edge.
    task automatic write1();
        dma_wr = 1'b1;
        tick();
        dma_wr = 1'b0;
    endtask

    task automatic pulse_sof();
        sof = 1'b1;
        tick();
        sof = 1'b0;
    endtask

    // Count strobes until the request falls; return how many were accepted.
    task automatic drain(input int limit, output int n);
        n = 0;
        settle();
        while (dma_req && n < limit) begin
            write1();
            n++;
            settle();
        end
    endtask

    initial begin
        int n;
        do_reset();
        settle();
        // R1
        chk("R1", "dma_req after reset", dma_req, 0);
        chk("R1", "size_err after reset", size_err, 0);

        // Sweep of sizes 0..7 against a 4-byte buffer across three frames.
        for (int s = 0; s < 8; s++) begin
            bit legal;
            do_reset();
            legal = (s != 0) && (s <= 4);
            ctl_size = CNT_W'(s); cfg_ep = 4'd3; buf_empty = 1'b1; ctl_start = 1'b1;
            settle();
            // R8
            chk("R8", $sformatf("size_err size=%0d", s), size_err, (s > 4) ? 1 : 0);
            tick();
            buf_empty = 1'b0;
            settle();
            // R2 R9 R8
            chk("R2", $sformatf("first req size=%0d", s), dma_req, legal ? 1 : 0);
            for (int f = 0; f < 3; f++) begin
                drain(20, n);
                // R4
                chk("R4", $sformatf("strobes size=%0d frame=%0d", s, f), n, legal ? s : 0);
                write1();   // extra strobe with request low must not count
                settle();
                chk("R4", $sformatf("req stays low size=%0d", s), dma_req, 0);
                pulse_sof();
                settle();
                // R5
                chk("R5", $sformatf("sof rearm size=%0d frame=%0d", s, f), dma_req, legal ? 1 : 0);
            end
        end

        // Error grid: size 0..5 against buffer 0..5.
        do_reset();
        cfg_ep = 4'd1; ctl_start = 1'b1;
        for (int b = 0; b < 6; b++) begin
            for (int s = 0; s < 6; s++) begin
                buf_size = CNT_W'(b); ctl_size = CNT_W'(s);
                settle();
                // R8
                chk("R8", $sformatf("grid size=%0d buf=%0d", s, b), size_err, (s > b) ? 1 : 0);
            end
        end
        cfg_ep = '0;
        buf_size = 11'd1; ctl_size = 11'd3;
        settle();
        chk("R2", "no error when unassigned", size_err, 0);

        // Buffer not empty at start: wait, then empty buffer arms.
        do_reset();
        ctl_size = 11'd3; cfg_ep = 4'd5; ctl_start = 1'b1;
        repeat (4) tick();
        // R3
        chk("R3", "no req while buffer full", dma_req, 0);
        buf_empty = 1'b1;
        settle();
        chk("R3", "req not yet same cycle", dma_req, 0);
        tick();
        chk("R3", "req after buffer empty", dma_req, 1);

        // Buffer not empty at start: SOF arms.
        do_reset();
        ctl_size = 11'd2; cfg_ep = 4'd5; ctl_start = 1'b1;
        repeat (3) tick();
        pulse_sof();
        settle();
        chk("R3", "req after sof with full buffer", dma_req, 1);

        // SOF mid-transfer restarts the count.
        do_reset();
        ctl_size = 11'd4; cfg_ep = 4'd2; buf_empty = 1'b1; ctl_start = 1'b1;
        tick();
        buf_empty = 1'b0;
        write1(); write1();
        pulse_sof();
        drain(20, n);
        // R6
        chk("R6", "strobes after mid-frame sof", n, 4);
        sof = 1'b1; dma_wr = 1'b1;   // sof and strobe together: sof wins
        tick();
        sof = 1'b0; dma_wr = 1'b0;
        drain(20, n);
        chk("R6", "strobes after sof with strobe", n, 4);

        // Clearing start mid-transfer.
        do_reset();
        ctl_size = 11'd4; cfg_ep = 4'd2; buf_empty = 1'b1; ctl_start = 1'b1;
        tick();
        buf_empty = 1'b0;
        write1(); write1();
        ctl_start = 1'b0;
        settle();
        // R7
        chk("R7", "req drops with start clear", dma_req, 0);
        tick();
        ctl_start = 1'b1;
        repeat (2) tick();
        chk("R7", "re-enable waits for sof", dma_req, 0);
        pulse_sof();
        drain(20, n);
        chk("R7", "full count after re-enable", n, 4);

        // Unbinding the endpoint mid-transfer.
        pulse_sof();
        write1();
        cfg_ep = '0;
        settle();
        chk("R7", "req drops with endpoint zero", dma_req, 0);
        tick();
        cfg_ep = 4'd9; buf_empty = 1'b1;
        tick();
        drain(20, n);
        chk("R7", "full count after rebind", n, 4);

        // Requests continue frame after frame.
        do_reset();
        ctl_size = 11'd2; cfg_ep = 4'd7; buf_empty = 1'b1; ctl_start = 1'b1;
        tick();
        buf_empty = 1'b0;
        for (int f = 0; f < 20; f++) begin
            drain(20, n);
            // R5
            chk("R5", $sformatf("long run frame=%0d", f), n, 2);
            repeat (3) tick();
            pulse_sof();
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule